// File: doc/BRIEF.md
# Region Enable Word to Address Range Extractor

This block turns a 32-bit region-enable word into at most three contiguous address ranges. A single-cycle start request loads the word. The block clears the word to a fixed mask and then steps through the bit positions one per clock, beginning at the most significant bit. Each enabled position stands for an address window of one of two sizes. The small windows are 16 MB and tile the top 256 MB of the 32-bit space. The large windows are 256 MB and tile the space from address zero upward.

Windows that follow directly on the previously accepted window are merged into the range being built. Any other enabled window opens a new range. Once three ranges are open, a window that needs a fourth range sets an overflow flag and ends the scan, and the first three ranges are kept.

A one-cycle done pulse marks the point where the range slots and the overflow flag are final. These results stay unchanged until the next accepted start.

Top module: `dre_range_extractor`

## Requirements
- R1: While reset is asserted, busy, done, overflow and every slot valid flag are 0, and every slot start and end address is 0.
- R2: The loaded word is ANDed with 0x003FFFFF before the scan. Bit 0 is never examined, so bits 31..22 and bit 0 never produce a range.
- R3: Scan position p (0 to 30) reads word bit 31-p. For p from 0 to 15, the window runs from 0xF0000000 + p*0x01000000 to that value + 0x00FFFFFF.
- R4: For p from 16 to 30, the window runs from (p-16)*0x10000000 to that value + 0x0FFFFFFF.
- R5: An enabled window whose start equals the previous accepted window's end plus one moves the current range's end to the window's end, so a run of adjacent windows gives one range with start <= end.
- R6: The end of position 15 (0xFFFFFFFF) plus one does not wrap to zero, so positions 15 and 16 always give two separate ranges.
- R7: Ranges fill slots 0, 1, 2 in scan order. A slot with valid 0 reads start 0 and end 0, and a slot is valid only if every lower slot is valid.
- R8: A window that needs a fourth range sets overflow and ends the scan at that position, leaving the three earlier ranges unchanged. Done follows in the next cycle.
- R9: Busy rises in the cycle after an accepted start. One position is evaluated per clock. Done is a one-cycle pulse, 31 cycles after the start edge for a full scan, and busy is low while done is high.
- R10: A start request while busy is ignored: the scan in progress and its result are unaffected.
- R11: An accepted start clears all slots and the overflow flag. The results then hold until done, and after done they hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request; accepted only when idle |
| decode_i | input | 32 | Region-enable word, sampled with an accepted start |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when results are final |
| rng_valid_o | output | 3 | Per-slot valid flags |
| rng_start_o | output | 3x32 | Per-slot first address |
| rng_end_o | output | 3x32 | Per-slot last address |
| overflow_o | output | 1 | More than three ranges were required |

## Verification
The properties assume that start_i and decode_i are synchronous and stable around the clock edge. They also assume that a start request arriving during a scan is dropped rather than queued, so the only results worth checking are those of the word taken when the block was idle. The stimulus changes every input on the falling edge. It holds start high for exactly one cycle per request, except where it deliberately raises start in the middle of a scan to test R10. Each new request waits until the previous done pulse has passed, so every result window is observed complete.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int ADDR_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [ADDR_W:0]   addr_ext_t;   // one spare bit so top-of-space + 1 does not wrap
endpackage

// File: rtl/dre_win_map.sv
// Maps a scan position to its address window (two granularities).
module dre_win_map
  import dre_pkg::*;
#(
  parameter int    IDX_W        = 5,
  parameter int    FINE_COUNT   = 16,
  parameter int    FINE_SHIFT   = 24,
  parameter int    COARSE_SHIFT = 28,
  parameter addr_t FINE_BASE    = 32'hF000_0000
) (
  input  logic [IDX_W-1:0] idx_i,
  output addr_t            lo_o,
  output addr_t            hi_o,
  output addr_ext_t        nxt_o
);
  localparam logic [IDX_W-1:0] FINE_LIM    = IDX_W'(FINE_COUNT);
  localparam addr_t            FINE_SPAN   = addr_t'((64'd1 << FINE_SHIFT) - 64'd1);
  localparam addr_t            COARSE_SPAN = addr_t'((64'd1 << COARSE_SHIFT) - 64'd1);

  always_comb begin
    if (idx_i < FINE_LIM) begin
      lo_o = FINE_BASE | (addr_t'(idx_i) << FINE_SHIFT);
      hi_o = lo_o + FINE_SPAN;
    end else begin
      lo_o = addr_t'(idx_i - FINE_LIM) << COARSE_SHIFT;
      hi_o = lo_o + COARSE_SPAN;
    end
    nxt_o = addr_ext_t'(hi_o) + addr_ext_t'(1);
  end
endmodule

// File: rtl/dre_scan_ctrl.sv
// Position counter, busy and done sequencing.
module dre_scan_ctrl #(
  parameter int IDX_W    = 5,
  parameter int LAST_IDX = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             load_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en, finish;

  always_comb begin
    load_o = start_i & ~busy_q;
    step_o = busy_q;
    finish = busy_q & (abort_i | (idx_q == LAST));
    idx_en = load_o | busy_q;
    idx_d  = load_o ? '0 : idx_q + IDX_W'(1);
    done_d = finish;
    if (load_o)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    else             busy_d = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/dre_range_bank.sv
// Range slots: merge adjacent windows, open new slots, flag overflow.
module dre_range_bank
  import dre_pkg::*;
#(
  parameter int NUM_RANGES = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       step_i,
  input  logic                       hit_i,
  input  addr_t                      lo_i,
  input  addr_t                      hi_i,
  input  addr_ext_t                  nxt_i,
  output logic                       abort_o,
  output logic  [NUM_RANGES-1:0]     valid_o,
  output addr_t [NUM_RANGES-1:0]     lo_o,
  output addr_t [NUM_RANGES-1:0]     hi_o,
  output logic                       ovf_o
);
  localparam int              CNT_W = $clog2(NUM_RANGES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_RANGES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  addr_ext_t        nxt_q, nxt_d;
  logic             ovf_q, ovf_d;
  logic             take, join_w, open_w;

  always_comb begin
    take    = step_i & hit_i;
    join_w  = take & (cnt_q != '0) & (addr_ext_t'(lo_i) == nxt_q);
    open_w  = take & ~join_w & (cnt_q != FULL);
    abort_o = take & ~join_w & (cnt_q == FULL);

    cnt_d = cnt_q;
    nxt_d = nxt_q;
    ovf_d = ovf_q;
    if (clear_i) begin
      cnt_d = '0;
      nxt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (open_w)          cnt_d = cnt_q + CNT_W'(1);
      if (open_w | join_w) nxt_d = nxt_i;
      if (abort_o)         ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      nxt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      nxt_q <= nxt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar k = 0; k < NUM_RANGES; k++) begin : g_slot
    logic  v_q, v_d;
    addr_t lo_q, lo_d, hi_q, hi_d;
    logic  wr_open, wr_ext;

    always_comb begin
      wr_open = open_w & (cnt_q == CNT_W'(k));
      wr_ext  = join_w & (cnt_q == CNT_W'(k + 1));
      v_d  = v_q;
      lo_d = lo_q;
      hi_d = hi_q;
      if (clear_i) begin
        v_d  = 1'b0;
        lo_d = '0;
        hi_d = '0;
      end else if (wr_open) begin
        v_d  = 1'b1;
        lo_d = lo_i;
        hi_d = hi_i;
      end else if (wr_ext) begin
        hi_d = hi_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q  <= 1'b0;
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        v_q  <= v_d;
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end

    assign valid_o[k] = v_q;
    assign lo_o[k]    = lo_q;
    assign hi_o[k]    = hi_q;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/dre_range_extractor.sv
module dre_range_extractor
  import dre_pkg::*;
#(
  parameter int    NUM_RANGES   = 3,
  parameter addr_t DECODE_MASK  = 32'h003F_FFFF,
  parameter int    LAST_IDX     = 30,
  parameter int    FINE_COUNT   = 16,
  parameter int    FINE_SHIFT   = 24,
  parameter int    COARSE_SHIFT = 28,
  parameter addr_t FINE_BASE    = 32'hF000_0000
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                start_i,
  input  logic [ADDR_W-1:0]                   decode_i,
  output logic                                busy_o,
  output logic                                done_o,
  output logic [NUM_RANGES-1:0]               rng_valid_o,
  output logic [NUM_RANGES-1:0][ADDR_W-1:0]   rng_start_o,
  output logic [NUM_RANGES-1:0][ADDR_W-1:0]   rng_end_o,
  output logic                                overflow_o
);
  localparam int               IDX_W   = $clog2(ADDR_W);
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(ADDR_W - 1);

  logic             load, step, abort, hit;
  logic [IDX_W-1:0] idx;
  addr_t            word_q, word_d;
  addr_t            win_lo, win_hi;
  addr_ext_t        win_nxt;

  always_comb begin
    word_d = load ? (decode_i & DECODE_MASK) : word_q;
    hit    = word_q[TOP_BIT - idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  dre_scan_ctrl #(
    .IDX_W    (IDX_W),
    .LAST_IDX (LAST_IDX)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .abort_i (abort),
    .load_o  (load),
    .step_o  (step),
    .idx_o   (idx),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  dre_win_map #(
    .IDX_W        (IDX_W),
    .FINE_COUNT   (FINE_COUNT),
    .FINE_SHIFT   (FINE_SHIFT),
    .COARSE_SHIFT (COARSE_SHIFT),
    .FINE_BASE    (FINE_BASE)
  ) u_map (
    .idx_i (idx),
    .lo_o  (win_lo),
    .hi_o  (win_hi),
    .nxt_o (win_nxt)
  );

  dre_range_bank #(
    .NUM_RANGES (NUM_RANGES)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .step_i  (step),
    .hit_i   (hit),
    .lo_i    (win_lo),
    .hi_i    (win_hi),
    .nxt_i   (win_nxt),
    .abort_o (abort),
    .valid_o (rng_valid_o),
    .lo_o    (rng_start_o),
    .hi_o    (rng_end_o),
    .ovf_o   (overflow_o)
  );
endmodule

// File: rtl/dre_checker.sv
module dre_checker #(
  parameter int NUM_RANGES = 3
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              start_i,
  input logic                              busy_o,
  input logic                              done_o,
  input logic [NUM_RANGES-1:0]             rng_valid_o,
  input logic [NUM_RANGES-1:0][31:0]       rng_start_o,
  input logic [NUM_RANGES-1:0][31:0]       rng_end_o,
  input logic                              overflow_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                                   // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);                                                   // R9
  AST_BUSY_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);                                             // R9
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !overflow_o && rng_valid_o == '0)); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(rng_valid_o) && $stable(overflow_o))); // R11
  AST_OVF_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (&rng_valid_o));                                        // R8

  for (genvar k = 0; k < NUM_RANGES; k++) begin : g_chk
    AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rng_valid_o[k] |-> (rng_start_o[k] == '0 && rng_end_o[k] == '0));  // R7
    AST_SPAN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rng_valid_o[k] |-> (rng_start_o[k] <= rng_end_o[k]));                 // R5
    if (k > 0) begin : g_fill
      AST_FILL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rng_valid_o[k] |-> rng_valid_o[k-1]);                               // R7
    end
  end
endmodule

bind dre_range_extractor dre_checker #(.NUM_RANGES(NUM_RANGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rng_valid_o (rng_valid_o),
  .rng_start_o (rng_start_o),
  .rng_end_o   (rng_end_o),
  .overflow_o  (overflow_o)
);

// File: tb/dre_range_extractor_tb.sv
`timescale 1ns/1ps
module dre_range_extractor_tb;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [31:0]      decode;
  logic             busy, done, ovf;
  logic [2:0]       valid;
  logic [2:0][31:0] r_lo, r_hi;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  dre_range_extractor u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .decode_i    (decode),
    .busy_o      (busy),
    .done_o      (done),
    .rng_valid_o (valid),
    .rng_start_o (r_lo),
    .rng_end_o   (r_hi),
    .overflow_o  (ovf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference
  logic [31:0] e_lo [3];
  logic [31:0] e_hi [3];
  bit          e_v  [3];
  bit          e_ovf;
  int          e_steps;
  string       cur_tag = "R1";

  task automatic predict(input logic [31:0] w);
    longint nxt = -1;
    longint b, e;
    int     n = 0;
    logic [31:0] m = w & 32'h003F_FFFF;
    e_ovf = 0;
    e_steps = 31;
    for (int s = 0; s < 3; s++) begin e_v[s] = 0; e_lo[s] = 0; e_hi[s] = 0; end
    for (int p = 0; p <= 30; p++) begin
      if (!m[31-p]) continue;
      if (p < 16) begin b = 64'hF000_0000 + longint'(p) * 64'h0100_0000; e = b + 64'h00FF_FFFF; end
      else        begin b = longint'(p - 16) * 64'h1000_0000;            e = b + 64'h0FFF_FFFF; end
      if (b != nxt) begin
        if (n == 3) begin e_ovf = 1; e_steps = p + 1; break; end
        e_v[n] = 1; e_lo[n] = b[31:0]; e_hi[n] = e[31:0]; n++;
      end else begin
        e_hi[n-1] = e[31:0];
      end
      nxt = e + 1;
    end
  endtask

  bit m_busy, m_done, m_first, m_have;
  int m_rem;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_first = 0; m_have = 0; m_rem = 0;
    end else begin
      m_done  = 0;
      m_first = 0;
      if (start && !m_busy) begin
        predict(decode);
        m_busy = 1; m_first = 1; m_have = 0; m_rem = e_steps;
      end else if (m_busy) begin
        if (m_rem == 1) begin m_busy = 0; m_done = 1; m_have = 1; end
        m_rem--;
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 busy", 64'(busy), 64'(m_busy));
      chk("R9 done", 64'(done), 64'(m_done));
      if (m_first) begin
        chk("R11 cleared valid", 64'(valid), 64'd0);
        chk("R11 cleared overflow", 64'(ovf), 64'd0);
      end
      if (!m_busy && m_have) begin
        chk({cur_tag, " overflow R8"}, 64'(ovf), 64'(e_ovf));
        for (int s = 0; s < 3; s++) begin
          chk({cur_tag, " valid R7"}, 64'(valid[s]), 64'(e_v[s]));
          chk({cur_tag, " start"},    64'(r_lo[s]),  64'(e_lo[s]));
          chk({cur_tag, " end"},      64'(r_hi[s]),  64'(e_hi[s]));
        end
      end
    end
  end

  task automatic run(input string tag, input logic [31:0] w,
                     input bit extra, input logic [31:0] w2);
    cur_tag = tag;
    @(negedge clk); start = 1'b1; decode = w;
    @(negedge clk); start = 1'b0; decode = 32'hDEAD_BEEF;
    if (extra) begin               // R10: request during a scan
      repeat (5) @(negedge clk);
      start = 1'b1; decode = w2;
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 60 && m_busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; decode = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 overflow", 64'(ovf), 64'd0);
    chk("R1 valid", 64'(valid), 64'd0);
    chk("R1 start", 64'(r_lo), 64'd0);
    chk("R1 end", 64'(r_hi), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run("R2 masked high bits", 32'hFFC0_0001, 0, 0);
    run("R2 lsb ignored",      32'h0000_0001, 0, 0);
    run("R3 fine window",      32'h0020_0000, 0, 0);
    run("R4 coarse window",    32'h0000_0002, 0, 0);
    run("R5 merge coarse",     32'h0000_7000, 0, 0);
    run("R6 no wrap merge",    32'h0001_8000, 0, 0);
    run("R5 full mask",        32'h003F_FFFF, 0, 0);
    run("R7 three slots",      32'h002A_0000, 0, 0);
    run("R8 overflow abort",   32'h002A_AAAA, 0, 0);
    run("R11 after overflow",  32'h0000_0002, 0, 0);
    run("R10 start ignored",   32'h0020_0000, 1, 32'h0000_000A);
    run("R9 fine pair",        32'h0030_0000, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule